// File: doc/BRIEF.md
# Scanline Vertical Counter Generator

This block keeps the vertical position of a video timing unit. Every time the scanline logic signals that a line has finished, it moves an 8-bit line number one step. An 8-bit value cannot count a 262-line frame directly, so the count folds back: on every other visit to 0xDA it returns to 0xD5 instead of going to 0xDB. A processor can read the line number at any time. A status port takes the interrupt flag from this block.

Alongside the counter, the block reports whether the current line is a visible display line. It raises a sticky frame interrupt when the visible area ends, and that interrupt stays set until an acknowledge pulse clears it. It also emits a one-cycle frame-start pulse every 262 line steps. That pulse comes from a separate step count and does not depend on the folded counter value.

Top module: `scanline_vcount`

## Requirements
- R1: After reset, `vcount` is 0x00, `active_line`, `frame_irq` and `frame_start` are 0, and the fold toggle is cleared, so the first visit to 0xDA folds.
- R2: A step is a clock edge at which `line_done` is high. A step at any value other than 0xDA increments `vcount` by one, and 0xFF wraps to 0x00. `vcount` does not change on an edge without a step.
- R3: A step at 0xDA flips the fold toggle. When the toggle becomes set, the next value is 0xD5. Otherwise the next value is 0xDB. After reset, the folds therefore happen on the 1st, 3rd, 5th, ... visits to 0xDA.
- R4: From 0x00, 262 steps bring `vcount` back to 0x00, so every frame runs through the same value sequence.
- R5: `active_line` is 1 exactly when `vcount` lies in 0x18 up to but not including 0xA8. It updates on the same edge as `vcount`.
- R6: The step that leaves the visible range (0xA7 to 0xA8) sets `frame_irq`. Once set, `frame_irq` stays 1 until it is acknowledged.
- R7: An `irq_ack` high at a clock edge clears `frame_irq`. If a setting step happens on the same edge, the set wins and `frame_irq` stays 1.
- R8: `frame_start` is high for one cycle after every 262nd step counted from reset. The first pulse follows the 262nd step.
- R9: Each edge with `line_done` high is one step, whether the pulses are isolated or back to back. The outputs show the result in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_done | input | 1 | One step of the line counter per clock edge while high |
| irq_ack | input | 1 | Clears the frame interrupt flag |
| vcount | output | 8 | Current vertical line number for processor readback |
| active_line | output | 1 | Current line is a visible display line |
| frame_irq | output | 1 | Sticky end-of-visible-area interrupt flag |
| frame_start | output | 1 | One-cycle pulse after each 262nd line step |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, 262 lines, a visible range of 0x18 to 0xA7, and a fold from 0xDA to 0xD5. With these values one frame is short enough to run in full, so every counter value is stepped through and compared. The fold and the plain pass at 0xDA, the 0xFF wrap and the frame-start pulse all occur within about 600 cycles. A second frame is then stepped up to 0xA7, where a step and an acknowledge are applied on the same edge to show that the set wins. Isolated steps separated by idle cycles then show that one pulse gives one step.

// File: rtl/vcount_pkg.sv
package vcount_pkg;
  // Fold toggle: PENDING means the next visit of the fold value jumps back
  typedef enum logic {
    FOLD_PENDING = 1'b0,
    FOLD_DONE    = 1'b1
  } fold_e;

  localparam int unsigned DEF_CNT_W     = 8;
  localparam int unsigned DEF_LINES     = 262;
  localparam int unsigned DEF_ACT_FIRST = 24;   // 0x18
  localparam int unsigned DEF_ACT_STOP  = 168;  // 0xA8, exclusive
  localparam int unsigned DEF_FOLD_AT   = 218;  // 0xDA
  localparam int unsigned DEF_FOLD_TO   = 213;  // 0xD5
endpackage

// File: rtl/vc_rst_sync.sv
module vc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/vc_line_counter.sv
module vc_line_counter
  import vcount_pkg::*;
#(
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned FOLD_AT = DEF_FOLD_AT,
  parameter int unsigned FOLD_TO = DEF_FOLD_TO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] AT_V  = CNT_W'(FOLD_AT);
  localparam logic [CNT_W-1:0] TO_V  = CNT_W'(FOLD_TO);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  fold_e            fold_q, fold_d;
  logic [CNT_W-1:0] cnt_d;

  // next-state
  always_comb begin
    cnt_d  = cnt_q;
    fold_d = fold_q;
    if (step) begin
      if (cnt_q == AT_V) begin
        fold_d = (fold_q == FOLD_PENDING) ? FOLD_DONE : FOLD_PENDING;
        cnt_d  = (fold_q == FOLD_PENDING) ? TO_V : cnt_q + ONE_V;
      end else begin
        cnt_d = cnt_q + ONE_V;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fold_q <= FOLD_PENDING;
    end else if (step) begin
      cnt_q  <= cnt_d;
      fold_q <= fold_d;
    end
  end

  assign cnt_nxt = cnt_d;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));
  assert_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != AT_V) |=> cnt_q == CNT_W'($past(cnt_q) + ONE_V));
  assert_fold_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == AT_V && fold_q == FOLD_PENDING) |=> cnt_q == TO_V);
  assert_fold_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == AT_V && fold_q == FOLD_DONE) |=> cnt_q == CNT_W'(AT_V + ONE_V));
endmodule

// File: rtl/vc_window.sv
module vc_window
  import vcount_pkg::*;
#(
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned ACT_FIRST = DEF_ACT_FIRST,
  parameter int unsigned ACT_STOP  = DEF_ACT_STOP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             ack,
  output logic             active_q,
  output logic             irq_q
);
  localparam int unsigned CW = CNT_W + 1;
  localparam logic [CW-1:0] FIRST_V = CW'(ACT_FIRST);
  localparam logic [CW-1:0] STOP_V  = CW'(ACT_STOP);

  logic nxt_inside;
  logic active_d;
  logic irq_set;
  logic irq_d;

  // next-state
  always_comb begin
    nxt_inside = ({1'b0, cnt_nxt} >= FIRST_V) && ({1'b0, cnt_nxt} < STOP_V);
    active_d   = step ? nxt_inside : active_q;
    irq_set    = step && active_q && !nxt_inside;
    irq_d      = irq_set | (irq_q & ~ack);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      irq_q    <= irq_d;
    end
  end

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack) |=> irq_q);
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(active_q) && !active_q));
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !step) |=> !irq_q);
endmodule

// File: rtl/vc_frame_tick.sv
module vc_frame_tick
  import vcount_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic pulse_q
);
  localparam int unsigned SW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [SW-1:0] LAST_V = SW'(LINES - 1);
  localparam logic [SW-1:0] ONE_V  = SW'(1);

  logic [SW-1:0] seen_q, seen_d;
  logic          pulse_d;

  // next-state
  always_comb begin
    pulse_d = step && (seen_q == LAST_V);
    seen_d  = seen_q;
    if (step) seen_d = (seen_q == LAST_V) ? '0 : seen_q + ONE_V;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (step) seen_q <= seen_d;
      pulse_q <= pulse_d;
    end
  end

  assert_pulse_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (seen_q == '0));
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && LINES > 1) |=> !pulse_q);
endmodule

// File: rtl/scanline_vcount.sv
module scanline_vcount
  import vcount_pkg::*;
#(
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned LINES     = DEF_LINES,
  parameter int unsigned ACT_FIRST = DEF_ACT_FIRST,
  parameter int unsigned ACT_STOP  = DEF_ACT_STOP,
  parameter int unsigned FOLD_AT   = DEF_FOLD_AT,
  parameter int unsigned FOLD_TO   = DEF_FOLD_TO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_done,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] vcount,
  output logic             active_line,
  output logic             frame_irq,
  output logic             frame_start
);
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt_nxt;

  vc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  vc_line_counter #(
    .CNT_W   (CNT_W),
    .FOLD_AT (FOLD_AT),
    .FOLD_TO (FOLD_TO)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step    (line_done),
    .cnt_q   (vcount),
    .cnt_nxt (cnt_nxt)
  );

  vc_window #(
    .CNT_W     (CNT_W),
    .ACT_FIRST (ACT_FIRST),
    .ACT_STOP  (ACT_STOP)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .step     (line_done),
    .cnt_nxt  (cnt_nxt),
    .ack      (irq_ack),
    .active_q (active_line),
    .irq_q    (frame_irq)
  );

  vc_frame_tick #(
    .LINES (LINES)
  ) u_frm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step    (line_done),
    .pulse_q (frame_start)
  );

  assert_window_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    active_line == (({1'b0, vcount} >= (CNT_W+1)'(ACT_FIRST)) &&
                    ({1'b0, vcount} <  (CNT_W+1)'(ACT_STOP))));
  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (vcount == '0 && !frame_irq && !frame_start && !active_line));
endmodule

// File: tb/sim_scanline_vcount.sv
module sim_scanline_vcount;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_done;
  logic       irq_ack;
  logic [7:0] vcount;
  logic       active_line;
  logic       frame_irq;
  logic       frame_start;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // bench model state
  logic [7:0] exp_v;
  bit         exp_t;
  bit         exp_irq;
  int         steps_seen;

  always #4 clk = ~clk;  // 125 MHz

  scanline_vcount u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_done   (line_done),
    .irq_ack     (irq_ack),
    .vcount      (vcount),
    .active_line (active_line),
    .frame_irq   (frame_irq),
    .frame_start (frame_start)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    compared = compared + 1;
    if (act !== exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_vis(logic [7:0] v);
    return (v >= 8'h18) && (v < 8'hA8);
  endfunction

  // one cycle: drive inputs, let one edge pass, compare at the next falling edge
  task automatic tick(bit ld, bit ack, string tag);
    bit was_vis;
    bit exp_fs;
    line_done = ld;
    irq_ack   = ack;
    was_vis   = in_vis(exp_v);
    exp_fs    = 1'b0;
    if (ld) begin
      if (exp_v == 8'hDA) begin
        exp_t = ~exp_t;
        exp_v = exp_t ? 8'hD5 : 8'hDB;
      end else begin
        exp_v = exp_v + 8'd1;
      end
      steps_seen = steps_seen + 1;
      if (steps_seen == 262) begin
        exp_fs = 1'b1;
        steps_seen = 0;
      end
    end
    if (ld && was_vis && !in_vis(exp_v)) exp_irq = 1'b1;
    else if (ack) exp_irq = 1'b0;
    @(negedge clk);
    line_done = 1'b0;
    irq_ack   = 1'b0;
    chk(tag,  "vcount",      vcount,      exp_v);
    chk("R5", "active_line", active_line, in_vis(exp_v));
    chk("R6/R7", "frame_irq", frame_irq,  exp_irq);
    chk("R8", "frame_start", frame_start, exp_fs);
  endtask

  task automatic t_reset();
    chk("R1", "vcount",      vcount,      0);
    chk("R1", "active_line", active_line, 0);
    chk("R1", "frame_irq",   frame_irq,   0);
    chk("R1", "frame_start", frame_start, 0);
  endtask

  task automatic t_idle();
    // no steps: counter holds; acknowledge with flag clear keeps it clear
    for (int i = 0; i < 4; i++) tick(1'b0, (i == 1), "R2");
  endtask

  task automatic t_full_frame();
    string tg;
    for (int i = 0; i < 262; i++) begin
      if (exp_v == 8'hDA)      tg = "R3";
      else if (exp_v == 8'hFF) tg = "R2";
      else                     tg = "R9";
      tick(1'b1, 1'b0, tg);
    end
    chk("R4", "vcount after frame", vcount, 0);
    chk("R6", "frame_irq held",     frame_irq, 1);
  endtask

  task automatic t_ack();
    tick(1'b0, 1'b1, "R7");
    chk("R7", "frame_irq after ack", frame_irq, 0);
  endtask

  task automatic t_collision();
    while (exp_v != 8'hA7) tick(1'b1, 1'b0, "R2");
    // set and acknowledge on the same edge: set wins
    tick(1'b1, 1'b1, "R7");
    chk("R7", "frame_irq set beats ack", frame_irq, 1);
    tick(1'b0, 1'b1, "R7");
  endtask

  task automatic t_isolated();
    for (int i = 0; i < 5; i++) begin
      tick(1'b1, 1'b0, "R9");
      tick(1'b0, 1'b0, "R9");
    end
  endtask

  task automatic t_second_frame_end();
    // continue to the end of frame two; fold pattern repeats (R3), frame pulse (R8)
    while (steps_seen != 0) tick(1'b1, 1'b0, (exp_v == 8'hDA) ? "R3" : "R4");
    chk("R4", "vcount after frame two", vcount, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    line_done = 1'b0;
    irq_ack = 1'b0;
    exp_v = 8'h00;
    exp_t = 1'b0;
    exp_irq = 1'b0;
    steps_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle();
    t_full_frame();
    t_ack();
    t_collision();
    t_isolated();
    t_second_frame_end();
    summary();
  end
endmodule